// File: doc/BRIEF.md
# Toggle-Strobe Word Exchange Between Unrelated Clocks

This block moves a wide data word from a sending clock domain (A) to a receiving clock domain (B) and carries a reply word back, with no assumed relation between the two clocks. Neither their frequency nor their phase needs to be related. In domain A, a send request captures a word, holds it steady on an internal bus, and inverts a single request strobe. Domain B passes that strobe through a flip-flop synchronizer. It sees any change of level as "a new word is present", captures the word and the reply value on its side, and then inverts a single acknowledge strobe. Domain A synchronizes the acknowledge strobe, takes the reply word and becomes free again.

A transfer costs one change on each strobe. Either polarity of change carries the same meaning, so no return-to-zero phase is needed. Only the two one-bit strobes cross through synchronizers. The data buses cross directly and are kept still by the side that launched them for as long as the other side may sample them.

Top module: `tgl_xfer_top`

## Requirements
- R1: While either reset is held and on the first cycles after it, `a_busy`, `a_reply_valid` and `b_valid` are low.
- R2: When `a_send` is high in an A cycle with `a_busy` low, the word on `a_data` is accepted and `a_busy` is high from the next A cycle.
- R3: A send request made while `a_busy` is high has no effect: no word is delivered for it, and the forward word and request strobe stay unchanged until the exchange ends.
- R4: Every accepted word appears exactly once on `b_data`, unaltered and in acceptance order, whatever the ratio of the two clock periods.
- R5: `b_valid` is high for exactly one B cycle per delivered word, and `b_data` holds that word from that cycle on.
- R6: The value on `b_reply_data` at the B clock edge that raises `b_valid` is returned on `a_reply_data`, qualified by a one-cycle pulse on `a_reply_valid`.
- R7: `a_reply_valid` is high in the A cycle where `a_busy` has just fallen: `a_busy` is low in that cycle and was high in the cycle before.
- R8: Each strobe changes level once per exchange, so successive exchanges alternate rising and falling changes, and both are taken as valid. A send made in the first A cycle after `a_busy` falls is accepted.
- R9: The acknowledge strobe changes level only in the B cycle that follows the capture of a word, and never otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Sending domain clock |
| rst_a_n | input | 1 | Sending domain reset, active low, asynchronous |
| a_send | input | 1 | Send request (A) |
| a_data | input | DATA_W | Word to send (A) |
| a_busy | output | 1 | Exchange in progress; further requests are ignored |
| a_reply_valid | output | 1 | One-cycle pulse: reply word available (A) |
| a_reply_data | output | RET_W | Reply word returned from B |
| clk_b | input | 1 | Receiving domain clock |
| rst_b_n | input | 1 | Receiving domain reset, active low, asynchronous |
| b_reply_data | input | RET_W | Reply value offered in domain B |
| b_valid | output | 1 | One-cycle pulse: new word on b_data (B) |
| b_data | output | DATA_W | Delivered word (B) |

## Verification
On every cycle, the assertions check the local sequencing rules in each domain. The forward word and request strobe stay frozen while busy. The strobe changes only from idle. The delivery pulse is one cycle wide. The acknowledge strobe moves only right after a capture. The reply pulse lines up with busy falling. Only the bench's scenarios show the end-to-end properties across the two clocks: each word arrives once, intact and in order, under unrelated periods; a request made while busy never shows up in B; and the reply value sampled in B is the one that reaches A.

// File: rtl/tgl_xfer_pkg.sv
package tgl_xfer_pkg;

    localparam int DEF_DATA_W      = 32;
    localparam int DEF_RET_W       = 16;
    localparam int DEF_SYNC_STAGES = 2;

    // A level change of a strobe, in either direction, marks a new event.
    function automatic logic strobe_moved(input logic now_lvl, input logic last_lvl);
        return now_lvl ^ last_lvl;
    endfunction

endpackage

// File: rtl/tgl_sync.sv
module tgl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain_d;
    logic [TOP:0] chain_q;

    generate
        if (STAGES < 2) begin : g_bad
            initial $error("tgl_sync needs at least two stages");
        end
    endgenerate

    always_comb begin
        chain_d = {chain_q[TOP-1:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[TOP];

endmodule

// File: rtl/tgl_src.sv
module tgl_src
    import tgl_xfer_pkg::*;
#(
    parameter int DATA_W      = DEF_DATA_W,
    parameter int RET_W       = DEF_RET_W,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              send,
    input  logic [DATA_W-1:0] send_data,
    input  logic              ack_tog,
    input  logic [RET_W-1:0]  ack_data,
    output logic              req_tog,
    output logic [DATA_W-1:0] req_data,
    output logic              busy,
    output logic              reply_valid,
    output logic [RET_W-1:0]  reply_data
);

    typedef struct packed {
        logic              tog;
        logic              busy;
        logic              ack_last;
        logic [DATA_W-1:0] word;
        logic              rvalid;
        logic [RET_W-1:0]  rword;
    } src_state_t;

    src_state_t st_d;
    src_state_t st_q;
    logic       ack_s;
    logic       ack_event;

    tgl_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ack_tog),
        .sync_out (ack_s)
    );

    assign ack_event = strobe_moved(ack_s, st_q.ack_last);

    always_comb begin
        st_d          = st_q;
        st_d.ack_last = ack_s;
        st_d.rvalid   = 1'b0;
        if (st_q.busy) begin
            if (ack_event) begin
                st_d.busy   = 1'b0;
                st_d.rvalid = 1'b1;
                st_d.rword  = ack_data;
            end
        end else if (send) begin
            st_d.word = send_data;
            st_d.tog  = ~st_q.tog;
            st_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_tog     = st_q.tog;
    assign req_data    = st_q.word;
    assign busy        = st_q.busy;
    assign reply_valid = st_q.rvalid;
    assign reply_data  = st_q.rword;

    // R3: nothing launched toward B moves while an exchange is open
    p_hold_while_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(st_q.busy) && st_q.busy |-> $stable(st_q.word) && $stable(st_q.tog));

    // R8: the request strobe moves only out of the idle state
    p_strobe_from_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.tog) |-> !$past(st_q.busy) && st_q.busy);

    // R7: the reply pulse marks the cycle in which busy has just dropped
    p_reply_ends_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rvalid |-> !st_q.busy && $past(st_q.busy));

    // R2: busy only rises where a request was offered
    p_busy_needs_send_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> $past(send));

endmodule

// File: rtl/tgl_dst.sv
module tgl_dst
    import tgl_xfer_pkg::*;
#(
    parameter int DATA_W      = DEF_DATA_W,
    parameter int RET_W       = DEF_RET_W,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_tog,
    input  logic [DATA_W-1:0] req_data,
    input  logic [RET_W-1:0]  reply_in,
    output logic              ack_tog,
    output logic [RET_W-1:0]  ack_data,
    output logic              valid,
    output logic [DATA_W-1:0] data
);

    typedef struct packed {
        logic              req_last;
        logic              valid;
        logic [DATA_W-1:0] word;
        logic [RET_W-1:0]  rword;
        logic              pend;
        logic              ack;
    } dst_state_t;

    dst_state_t st_d;
    dst_state_t st_q;
    logic       req_s;
    logic       req_event;

    tgl_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (req_tog),
        .sync_out (req_s)
    );

    assign req_event = strobe_moved(req_s, st_q.req_last);

    always_comb begin
        st_d          = st_q;
        st_d.req_last = req_s;
        st_d.valid    = 1'b0;
        st_d.pend     = 1'b0;
        if (st_q.pend) begin
            st_d.ack = ~st_q.ack;
        end
        if (req_event) begin
            st_d.valid = 1'b1;
            st_d.word  = req_data;
            st_d.rword = reply_in;
            st_d.pend  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack_tog  = st_q.ack;
    assign ack_data = st_q.rword;
    assign valid    = st_q.valid;
    assign data     = st_q.word;

    // R5: delivery pulse lasts a single B cycle
    p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |=> !st_q.valid);

    // R9: acknowledge strobe moves only right after a capture
    p_ack_after_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.ack) |-> $past(st_q.valid));

    // R6: reply word is steady when the acknowledge strobe moves
    p_reply_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.ack) |-> $stable(st_q.rword));

endmodule

// File: rtl/tgl_xfer_top.sv
module tgl_xfer_top
    import tgl_xfer_pkg::*;
#(
    parameter int DATA_W      = DEF_DATA_W,
    parameter int RET_W       = DEF_RET_W,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic              clk_a,
    input  logic              rst_a_n,
    input  logic              a_send,
    input  logic [DATA_W-1:0] a_data,
    output logic              a_busy,
    output logic              a_reply_valid,
    output logic [RET_W-1:0]  a_reply_data,
    input  logic              clk_b,
    input  logic              rst_b_n,
    input  logic [RET_W-1:0]  b_reply_data,
    output logic              b_valid,
    output logic [DATA_W-1:0] b_data
);

    logic              req_tog;
    logic [DATA_W-1:0] req_data;
    logic              ack_tog;
    logic [RET_W-1:0]  ack_data;

    tgl_src #(
        .DATA_W      (DATA_W),
        .RET_W       (RET_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_src (
        .clk         (clk_a),
        .rst_n       (rst_a_n),
        .send        (a_send),
        .send_data   (a_data),
        .ack_tog     (ack_tog),
        .ack_data    (ack_data),
        .req_tog     (req_tog),
        .req_data    (req_data),
        .busy        (a_busy),
        .reply_valid (a_reply_valid),
        .reply_data  (a_reply_data)
    );

    tgl_dst #(
        .DATA_W      (DATA_W),
        .RET_W       (RET_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_dst (
        .clk      (clk_b),
        .rst_n    (rst_b_n),
        .req_tog  (req_tog),
        .req_data (req_data),
        .reply_in (b_reply_data),
        .ack_tog  (ack_tog),
        .ack_data (ack_data),
        .valid    (b_valid),
        .data     (b_data)
    );

endmodule

// File: tb/tgl_xfer_top_test.sv
`timescale 1ns/1ps
module tgl_xfer_top_test;

    localparam int DW = 32;
    localparam int RW = 16;
    localparam int NWORDS = 24;

    logic          clk_a = 1'b0;
    logic          clk_b = 1'b0;
    logic          rst_a_n = 1'b0;
    logic          rst_b_n = 1'b0;
    logic          a_send = 1'b0;
    logic [DW-1:0] a_data = '0;
    logic          a_busy;
    logic          a_reply_valid;
    logic [RW-1:0] a_reply_data;
    logic [RW-1:0] b_reply_data;
    logic          b_valid;
    logic [DW-1:0] b_data;

    int checks = 0;
    int fails  = 0;
    int n_rx   = 0;
    int n_rep  = 0;
    bit done   = 1'b0;
    logic [DW-1:0] fwd_q[$];

    always #10   clk_a = ~clk_a;
    always #18.5 clk_b = ~clk_b;

    tgl_xfer_top #(.DATA_W(DW), .RET_W(RW), .SYNC_STAGES(2)) uut (
        .clk_a         (clk_a),
        .rst_a_n       (rst_a_n),
        .a_send        (a_send),
        .a_data        (a_data),
        .a_busy        (a_busy),
        .a_reply_valid (a_reply_valid),
        .a_reply_data  (a_reply_data),
        .clk_b         (clk_b),
        .rst_b_n       (rst_b_n),
        .b_reply_data  (b_reply_data),
        .b_valid       (b_valid),
        .b_data        (b_data)
    );

    function automatic logic [RW-1:0] reply_for(input int k);
        return RW'(16'hA500 ^ (k * 37));
    endfunction

    function automatic logic [DW-1:0] word_for(input int k);
        return DW'(32'h1357_0000 + k * 32'h0101_0011);
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // B side monitor: delivery order, content, pulse width, reply value
    initial begin
        logic prev_v = 1'b0;
        b_reply_data = reply_for(0);
        forever begin
            @(negedge clk_b);
            if (rst_b_n) begin
                if (b_valid) begin
                    check(!prev_v, "R5 b_valid wider than one cycle", 1, 0);
                    if (fwd_q.size() == 0) begin
                        check(1'b0, "R3 R4 unexpected delivery", b_data, 0);
                    end else begin
                        logic [DW-1:0] exp_w;
                        exp_w = fwd_q.pop_front();
                        check(b_data == exp_w, "R4 delivered word", b_data, exp_w);
                    end
                    n_rx++;
                    b_reply_data = reply_for(n_rx);
                end
                prev_v = b_valid;
            end
        end
    end

    // A side monitor: reply content and alignment with busy
    initial begin
        logic prev_busy = 1'b0;
        forever begin
            @(negedge clk_a);
            if (rst_a_n) begin
                if (a_reply_valid) begin
                    check(a_reply_data == reply_for(n_rep), "R6 reply word",
                          a_reply_data, reply_for(n_rep));
                    check(!a_busy && prev_busy, "R7 reply pulse vs busy edge",
                          {a_busy, prev_busy}, 2'b01);
                    n_rep++;
                end
                prev_busy = a_busy;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk_a);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R4 watchdog expired actual=%0d expected=%0d", n_rep, NWORDS);
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk_a);
        check(a_busy == 1'b0, "R1 a_busy in reset", a_busy, 0);
        check(a_reply_valid == 1'b0, "R1 a_reply_valid in reset", a_reply_valid, 0);
        check(b_valid == 1'b0, "R1 b_valid in reset", b_valid, 0);
        rst_b_n = 1'b1;
        @(negedge clk_a);
        rst_a_n = 1'b1;
        repeat (3) @(negedge clk_a);
        check(a_busy == 1'b0, "R1 a_busy after reset", a_busy, 0);
        check(b_valid == 1'b0, "R1 b_valid after reset", b_valid, 0);

        for (int k = 0; k < NWORDS; k++) begin
            while (a_busy) @(negedge clk_a);
            if (k % 5 == 3) repeat (k % 3 + 1) @(negedge clk_a);
            a_send = 1'b1;
            a_data = word_for(k);
            fwd_q.push_back(word_for(k));
            @(negedge clk_a);
            if (k == 0) check(a_busy == 1'b1, "R2 busy after accepted send", a_busy, 1);
            else        check(a_busy == 1'b1, "R8 back-to-back send accepted", a_busy, 1);
            // R3: keep requesting with other data while busy
            if (k % 2 == 1) begin
                for (int j = 0; j < 4; j++) begin
                    if (a_busy) begin
                        a_send = 1'b1;
                        a_data = ~word_for(k) ^ DW'(j);
                    end else begin
                        a_send = 1'b0;
                    end
                    @(negedge clk_a);
                end
            end
            a_send = 1'b0;
        end

        while (n_rep < NWORDS) @(negedge clk_a);
        repeat (20) @(negedge clk_a);
        check(n_rx == NWORDS, "R3 R4 delivered count", n_rx, NWORDS);
        check(fwd_q.size() == 0, "R4 words left undelivered", fwd_q.size(), 0);
        check(n_rep == NWORDS, "R6 reply count", n_rep, NWORDS);
        check(a_busy == 1'b0, "R7 idle at end", a_busy, 0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule